// File: doc/BRIEF.md
# Converter Sample Queue with Host Status Port

This block sits between a sampling converter and a host processor. Each finished conversion arrives as a 12-bit word on an end-of-conversion strobe, along with a flag that marks the sample as out of range. The block holds up to eight such words in first-in first-out order, and the host drains them over a 12-bit parallel bus. One address line picks what the host sees: the oldest queued sample, or a combined status/control word.

The status/control word lets software do four things:
- watch the fill level and see whether the queue is empty;
- find out whether any queued sample is out of range, or whether the next one is;
- see whether a sample was lost because the queue was full;
- set a fill level at which an active-low almost-full line tells the host to come and drain.

Writing the same word sets that threshold, masks the almost-full line, limits when the data bus may drive, and can reset the whole block. The bus is modelled with synchronous read and write strobes qualified by a chip select. A separate drive-enable output stands in for the tri-state control.

Top module: `sample_fifo_host`

## Requirements
- R1: Up to 8 samples are held. A data read (chip select and read high, address low) returns the oldest held sample and, if the queue is not empty, removes it, so words come out in arrival order.
- R2: A conversion that arrives while 8 words are held, with no data read in the same cycle, is dropped. Status bit 6 then reads 1 until the next reset.
- R3: Status bit 4 reads 1 when no sample is held. A data read on an empty queue removes nothing and returns the last word that location 0 held.
- R4: Status bits 2..0 read the number of held words minus one, or 0 when the queue is empty.
- R5: Bits 10..8 written to the control word set a code N, which reads back in status bits 10..8. The almost-full output and status bit 11 go low when the number of held words equals N+1. Both are evaluated only on an end-of-conversion strobe.
- R6: Control bit 7 written as 1 forces the almost-full output and status bit 11 high. Written as 0, the last evaluated state is shown again. The bit reads back as status bit 7.
- R7: A control write with bit 6 set resets the block exactly as the reset input does.
- R8: Status bit 5 reads 1 when any held sample carries the out-of-range flag. Status bit 3 reads 1 when the oldest held sample carries it. Both read 0 when the queue is empty.
- R9: The drive-enable output is high during a read with chip select. The exception is when control bit 5 was last written 0 and the busy input is low; then it stays low.
- R10: A read with the address high returns the status word and leaves the queue's contents and word count unchanged.
- R11: An end-of-conversion strobe that coincides with a data read both removes the oldest word and stores the new one, so the word count is unchanged and the order is kept.
- R12: After reset the status word reads 0x810: almost-full high, code 0, the mask bit 0, the sticky flags clear, and the queue empty. The almost-full output is high and control bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eocStrobe | input | 1 | End-of-conversion strobe, one cycle per sample |
| sampleIn | input | 12 | Conversion result |
| sampleOor | input | 1 | Out-of-range flag for sampleIn |
| chipSel | input | 1 | Bus chip select, active high |
| rdStrobe | input | 1 | Bus read strobe |
| wrStrobe | input | 1 | Bus write strobe |
| addrSel | input | 1 | 0 selects sample data, 1 selects the status/control word |
| wrData | input | 12 | Bus write data |
| busyN | input | 1 | Converter busy, active low |
| rdData | output | 12 | Bus read data |
| busDrive | output | 1 | Bus drive enable |
| almostFullN | output | 1 | Almost-full flag, active low |

## Verification
The embedded assertions check several rules on every cycle:
- the word count never exceeds eight;
- no word is removed while the queue is empty;
- location 0 holds steady while the queue is empty;
- the overrun bit is sticky;
- the almost-full state moves only on a conversion strobe;
- a status read leaves the count alone;
- a software reset empties the queue.

Only the directed scenarios can show what the host actually reads back. That covers:
- arrival order and the loss of the ninth word;
- the exact status encodings, including the count field that reads 0 for both one word and none;
- the threshold arithmetic of the almost-full code;
- the masking bit, and drive-enable gating against busy;
- a read and a conversion landing in the same cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Strobes from the control side to the sample store
  typedef struct packed {
    logic push;    // store the incoming sample
    logic pop;     // retire the word in location 0
    logic clear;   // empty the store
    logic evalAf;  // re-evaluate almost-full this cycle
  } fifoCmd_t;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrWord,
  input  logic              wrOor,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] headWord,
  output logic              headOor,
  output logic              anyOor
);
  logic [DEPTH-1:0][DATA_W-1:0] dataQ, dataD;
  logic [DEPTH-1:0]             oorQ, oorD;
  logic [DEPTH-1:0]             validMask;
  logic [CNT_W-1:0]             countQ, countD, wrIdx;
  logic                         shiftNow;

  // location i holds a valid word when i < count
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    assign validMask[i] = (CNT_W'(i) < countQ);
  end

  // a pop of the only word leaves location 0 in place so it can still be read
  assign shiftNow = cmd.pop && (countQ > CNT_W'(1));
  assign wrIdx    = countQ - CNT_W'(cmd.pop);

  always_comb begin
    dataD = dataQ;
    oorD  = oorQ;
    if (shiftNow) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        dataD[i] = dataQ[i+1];
        oorD[i]  = oorQ[i+1];
      end
    end
    if (cmd.push) begin
      dataD[wrIdx[IDX_W-1:0]] = wrWord;
      oorD[wrIdx[IDX_W-1:0]]  = wrOor;
    end
    countD = countQ + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      dataQ  <= '0;
      oorQ   <= '0;
      countQ <= '0;
    end else begin
      dataQ  <= dataD;
      oorQ   <= oorD;
      countQ <= countD;
    end
  end

  assign count    = countQ;
  assign headWord = dataQ[0];
  assign headOor  = oorQ[0] && (countQ != '0);
  assign anyOor   = |(oorQ & validMask);

  // R1: occupancy stays within the store
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    countQ <= CNT_W'(DEPTH));
  // R2: the control side never stores into a full queue without retiring one
  a_r2_no_push_full: assert property (@(posedge clk) disable iff (rst)
    (cmd.push && countQ == CNT_W'(DEPTH)) |-> cmd.pop);
  // R3: nothing is retired from an empty queue
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (countQ == '0) |-> !cmd.pop);
  // R3: location 0 is kept while empty
  a_r3_head_hold: assert property (@(posedge clk) disable iff (rst)
    (countQ == '0 && !cmd.push && !cmd.clear) |=> $stable(dataQ[0]));
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eocStrobe,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busyN,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] headWord,
  input  logic              headOor,
  input  logic              anyOor,
  output fifoCmd_t          cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              busDrive,
  output logic              almostFullN
);
  // positions of the status/control fields
  localparam int B_AFN  = 11;
  localparam int B_AFC  = 8;
  localparam int B_MASK = 7;
  localparam int B_OVR  = 6;
  localparam int B_ANY  = 5;
  localparam int B_EMP  = 4;
  localparam int B_HEAD = 3;

  logic [IDX_W-1:0]  afCodeQ;
  logic              afMaskQ, allowBusyQ, overrunQ, afMatchQ;
  logic              dataRead, statusRead, ctrlWrite, swReset, isEmpty;
  logic [CNT_W-1:0]  afterCount;
  logic [IDX_W-1:0]  topIdx;
  logic [DATA_W-1:0] statusWord;

  assign dataRead   = chipSel && rdStrobe && !addrSel;
  assign statusRead = chipSel && rdStrobe && addrSel;
  assign ctrlWrite  = chipSel && wrStrobe && addrSel;
  assign swReset    = ctrlWrite && wrData[B_OVR];
  assign isEmpty    = (count == '0);

  always_comb begin
    cmd.clear  = swReset;
    cmd.pop    = dataRead && !isEmpty && !swReset;
    cmd.push   = eocStrobe && !swReset &&
                 ((count < CNT_W'(DEPTH)) || cmd.pop);
    cmd.evalAf = eocStrobe && !swReset;
    afterCount = count + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
  end

  always_ff @(posedge clk) begin
    if (rst || swReset) begin
      afCodeQ    <= '0;
      afMaskQ    <= 1'b0;
      allowBusyQ <= 1'b1;
      overrunQ   <= 1'b0;
      afMatchQ   <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        afCodeQ    <= wrData[B_AFC +: IDX_W];
        afMaskQ    <= wrData[B_MASK];
        allowBusyQ <= wrData[B_ANY];
      end
      if (eocStrobe && !cmd.push) overrunQ <= 1'b1;
      if (cmd.evalAf)
        afMatchQ <= (afterCount == CNT_W'(afCodeQ) + CNT_W'(1));
    end
  end

  assign almostFullN = !(afMatchQ && !afMaskQ);
  assign topIdx      = isEmpty ? '0 : IDX_W'(count - CNT_W'(1));

  always_comb begin
    statusWord                 = '0;
    statusWord[B_AFN]          = almostFullN;
    statusWord[B_AFC +: IDX_W] = afCodeQ;
    statusWord[B_MASK]         = afMaskQ;
    statusWord[B_OVR]          = overrunQ;
    statusWord[B_ANY]          = anyOor;
    statusWord[B_EMP]          = isEmpty;
    statusWord[B_HEAD]         = headOor;
    statusWord[IDX_W-1:0]      = topIdx;
  end

  assign rdData   = addrSel ? statusWord : headWord;
  assign busDrive = chipSel && rdStrobe && (busyN || allowBusyQ);

  // R2: the lost-sample flag is sticky
  a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrunQ && !swReset) |=> overrunQ);
  // R5: almost-full state moves only on a conversion strobe
  a_r5_af_eoc_only: assert property (@(posedge clk) disable iff (rst)
    (!eocStrobe && !swReset) |=> $stable(afMatchQ));
  // R10: a status read leaves the queue alone
  a_r10_status_quiet: assert property (@(posedge clk) disable iff (rst)
    (statusRead && !eocStrobe && !wrStrobe) |=> $stable(count));
  // R7: a software reset empties the queue and releases almost-full
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (rst)
    swReset |=> (count == '0 && almostFullN));
endmodule

// File: rtl/sample_fifo_host.sv
module sample_fifo_host
  import sfifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eocStrobe,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              sampleOor,
  input  logic              chipSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busyN,
  output logic [DATA_W-1:0] rdData,
  output logic              busDrive,
  output logic              almostFullN
);
  fifoCmd_t          cmd;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] headWord;
  logic              headOor, anyOor;

  sfifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .eocStrobe(eocStrobe), .chipSel(chipSel),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .addrSel(addrSel),
    .wrData(wrData), .busyN(busyN), .count(count), .headWord(headWord),
    .headOor(headOor), .anyOor(anyOor), .cmd(cmd), .rdData(rdData),
    .busDrive(busDrive), .almostFullN(almostFullN)
  );

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .cmd(cmd), .wrWord(sampleIn), .wrOor(sampleOor),
    .count(count), .headWord(headWord), .headOor(headOor), .anyOor(anyOor)
  );
endmodule

// File: tb/sim_sample_fifo_host.sv
module sim_sample_fifo_host;
  logic clk = 0, rst = 1, eocStrobe = 0, sampleOor = 0;
  logic chipSel = 0, rdStrobe = 0, wrStrobe = 0, addrSel = 0, busyN = 1;
  logic [11:0] sampleIn = '0, wrData = '0, rdData;
  logic busDrive, almostFullN;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sample_fifo_host u0 (
    .clk(clk), .rst(rst), .eocStrobe(eocStrobe), .sampleIn(sampleIn),
    .sampleOor(sampleOor), .chipSel(chipSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .addrSel(addrSel), .wrData(wrData), .busyN(busyN),
    .rdData(rdData), .busDrive(busDrive), .almostFullN(almostFullN)
  );

  function automatic logic [11:0] mk(logic afn, logic [2:0] afc, logic msk,
      logic ovr, logic any, logic emp, logic hd, logic [2:0] idx);
    return {afn, afc, msk, ovr, any, emp, hd, idx};
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic pushS(logic [11:0] d, logic o);
    @(negedge clk); eocStrobe = 1; sampleIn = d; sampleOor = o;
    @(negedge clk); eocStrobe = 0;
  endtask

  task automatic readBus(logic a, output logic [11:0] v, output logic drv);
    @(negedge clk); chipSel = 1; rdStrobe = 1; addrSel = a;
    #1 v = rdData; drv = busDrive;
    @(negedge clk); chipSel = 0; rdStrobe = 0; addrSel = 0;
  endtask

  task automatic writeCtrl(logic [11:0] v);
    @(negedge clk); chipSel = 1; wrStrobe = 1; addrSel = 1; wrData = v;
    @(negedge clk); chipSel = 0; wrStrobe = 0; addrSel = 0; wrData = '0;
  endtask

  task automatic testReset();
    logic [11:0] v; logic d;
    doReset();
    readBus(1, v, d);
    check("R12 reset status", v, 12'h810);
    check("R12 reset almostFullN", {11'b0, almostFullN}, 12'h1);
  endtask

  task automatic testOrder();
    logic [11:0] v; logic d;
    doReset();
    for (int i = 0; i < 5; i++) pushS(12'h101 + 12'(i), 0);
    readBus(1, v, d);
    check("R4 index with 5 words", v, mk(1,0,0,0,0,0,0,4));
    for (int i = 0; i < 5; i++) begin
      readBus(0, v, d);
      check("R1 arrival order", v, 12'h101 + 12'(i));
    end
    readBus(1, v, d);
    check("R3 empty status", v, mk(1,0,0,0,0,1,0,0));
    readBus(0, v, d);
    check("R3 empty read holds last word", v, 12'h105);
    readBus(0, v, d);
    check("R3 repeated empty read", v, 12'h105);
    readBus(1, v, d);
    check("R3 still empty", v, mk(1,0,0,0,0,1,0,0));
  endtask

  task automatic testOverrun();
    logic [11:0] v; logic d;
    doReset();
    for (int i = 0; i < 9; i++) pushS(12'h200 + 12'(i), 0);
    readBus(1, v, d);
    check("R2 full with overrun", v, mk(1,0,0,1,0,0,0,7));
    for (int i = 0; i < 8; i++) begin
      readBus(0, v, d);
      check("R2 ninth word dropped", v, 12'h200 + 12'(i));
    end
    readBus(1, v, d);
    check("R2 overrun sticky after drain", v, mk(1,0,0,1,0,1,0,0));
  endtask

  task automatic testOor();
    logic [11:0] v; logic d;
    doReset();
    pushS(12'h300, 0);
    pushS(12'h301, 1);
    readBus(1, v, d);
    check("R8 any out of range", v, mk(1,0,0,0,1,0,0,1));
    readBus(0, v, d);
    check("R8 head word", v, 12'h300);
    readBus(1, v, d);
    check("R8 head out of range", v, mk(1,0,0,0,1,0,1,0));
    readBus(0, v, d);
    readBus(1, v, d);
    check("R8 cleared when empty", v, mk(1,0,0,0,0,1,0,0));
  endtask

  task automatic testAlmostFull();
    logic [11:0] v; logic d;
    doReset();
    writeCtrl(12'h320);
    for (int i = 0; i < 3; i++) pushS(12'h400 + 12'(i), 0);
    check("R5 three words flag high", {11'b0, almostFullN}, 12'h1);
    pushS(12'h403, 0);
    check("R5 four words flag low", {11'b0, almostFullN}, 12'h0);
    readBus(1, v, d);
    check("R5 status bit 11 and code readback", v, mk(0,3,0,0,0,0,0,3));
    readBus(0, v, d);
    check("R5 flag held without conversion", {11'b0, almostFullN}, 12'h0);
    pushS(12'h404, 0);
    check("R5 back to four words", {11'b0, almostFullN}, 12'h0);
    pushS(12'h405, 0);
    check("R5 five words flag high", {11'b0, almostFullN}, 12'h1);
  endtask

  task automatic testMask();
    logic [11:0] v; logic d;
    doReset();
    writeCtrl(12'h3A0);
    for (int i = 0; i < 4; i++) pushS(12'h450 + 12'(i), 0);
    check("R6 masked pin", {11'b0, almostFullN}, 12'h1);
    readBus(1, v, d);
    check("R6 masked status", v, mk(1,3,1,0,0,0,0,3));
    writeCtrl(12'h320);
    check("R6 unmasked pin", {11'b0, almostFullN}, 12'h0);
  endtask

  task automatic testStatusQuiet();
    logic [11:0] v; logic d;
    doReset();
    pushS(12'h501, 0);
    pushS(12'h502, 0);
    for (int i = 0; i < 3; i++) begin
      readBus(1, v, d);
      check("R10 status read repeatable", v, mk(1,0,0,0,0,0,0,1));
    end
    readBus(0, v, d);
    check("R10 data untouched", v, 12'h501);
  endtask

  task automatic testSimul();
    logic [11:0] v;
    logic d;
    doReset();
    pushS(12'h601, 0);
    pushS(12'h602, 0);
    @(negedge clk);
    eocStrobe = 1; sampleIn = 12'h603; chipSel = 1; rdStrobe = 1; addrSel = 0;
    #1 v = rdData;
    @(negedge clk);
    eocStrobe = 0; chipSel = 0; rdStrobe = 0;
    check("R11 read during push", v, 12'h601);
    readBus(1, v, d);
    check("R11 count kept", v, mk(1,0,0,0,0,0,0,1));
    readBus(0, v, d);
    check("R11 order 2", v, 12'h602);
    readBus(0, v, d);
    check("R11 order 3", v, 12'h603);
  endtask

  task automatic testSoftReset();
    logic [11:0] v; logic d;
    doReset();
    writeCtrl(12'h320);
    for (int i = 0; i < 4; i++) pushS(12'h700 + 12'(i), 0);
    writeCtrl(12'h040);
    readBus(1, v, d);
    check("R7 software reset status", v, 12'h810);
    check("R7 software reset pin", {11'b0, almostFullN}, 12'h1);
  endtask

  task automatic testDrive();
    logic [11:0] v; logic d;
    doReset();
    busyN = 0;
    readBus(0, v, d);
    check("R9 drive allowed after reset", {11'b0, d}, 12'h1);
    writeCtrl(12'h000);
    readBus(0, v, d);
    check("R9 drive blocked while busy", {11'b0, d}, 12'h0);
    busyN = 1;
    readBus(0, v, d);
    check("R9 drive when not busy", {11'b0, d}, 12'h1);
    @(negedge clk); rdStrobe = 1; chipSel = 0;
    #1 check("R9 no drive without select", {11'b0, busDrive}, 12'h0);
    @(negedge clk); rdStrobe = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    testReset();
    testOrder();
    testOverrun();
    testOor();
    testAlmostFull();
    testMask();
    testStatusQuiet();
    testSimul();
    testSoftReset();
    testDrive();
    finishRun();
  end
endmodule